// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The controller sits between a set of interrupting devices and a processor. It merges every enabled, unmasked device request into a single request line for the processor. When the processor answers with its grant, the controller routes that grant to exactly one device, the highest-priority one that was eligible when the grant arrived. For as long as the grant stays high, it also drives that device's identification code on a vector output.

Priority is fixed, and a lower device number wins. The winner is chosen in the first cycle of a grant and is held until the grant drops, even if the requests change in the meantime. The vector is a programmable base plus the device number. Each raw request line is also visible on a status output, so software can poll for the source when it does not use the vector.

The vector output does not use a separate ready signal for back-pressure. It carries a valid strobe, and the processor's grant acts as the hold condition: code and strobe stay fixed for every cycle the grant is high, and they are withdrawn in the same cycle that the grant falls. Requests are levels. A device removes its request after it sees its grant line, and requests that lose arbitration simply stay pending.

Top module: `vec_irq_ctrl`

## Requirements
- R1: `cpu_irq` is high in the same cycle, combinationally, exactly when `en_in` is 1 and at least one device has `irq_in[i]`=1 with `mask_in[i]`=0.
- R2: `pend_stat[i]` equals `irq_in[i]` in every cycle, whatever the mask and enable.
- R3: While `cpu_grant` is high, at most one bit of `dev_ack` is set. It is the lowest index i that was eligible (request 1, mask 0, enable 1) in the first cycle of that grant.
- R4: The device chosen in the first grant cycle keeps its `dev_ack` bit and its vector until `cpu_grant` falls, even if requests, mask or enable change meanwhile.
- R5: `vec_valid` is 1 exactly in grant cycles that have a chosen device. In those cycles `vec_data` = `vec_base` + i (8-bit wrap); otherwise `vec_data` is 0 and `dev_ack` is all zero.
- R6: A device whose mask bit is 1, or any device while `en_in` is 0, is never chosen and does not drive `cpu_irq`.
- R7: If no device is eligible in the first cycle of a grant, then no `dev_ack` bit and no `vec_valid` is produced for the whole of that grant, even if a request arrives later.
- R8: A request that loses arbitration is kept. It is chosen at a later grant once the higher ones are gone.
- R9: During and right after active-low reset `rst_n`, with the grant low, `dev_ack`, `vec_valid` and `vec_data` are 0. A grant high in the first cycle after reset counts as a new grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_in | input | 1 | Global interrupt enable |
| irq_in | input | N_SRC | Device request levels |
| mask_in | input | N_SRC | Per-device mask, 1 blocks the device |
| vec_base | input | VEC_W | Base of the vector codes |
| cpu_grant | input | 1 | Processor grant / acknowledge |
| cpu_irq | output | 1 | Combined request to the processor |
| dev_ack | output | N_SRC | Per-device grant lines |
| vec_valid | output | 1 | Vector strobe |
| vec_data | output | VEC_W | Identification code of the granted device |
| pend_stat | output | N_SRC | Pollable request status bits |

## Verification
On every cycle, the assertions check that the per-device grant is one-hot or zero and is backed by a vector strobe, and that the strobe never appears without the processor grant. They also check that the latched choice does not move during a grant, and that the first granted device was requesting and unmasked. Only the bench scenarios can show which device wins among simultaneous requests, that a grant arriving with nothing eligible stays empty, that losers are served at later grants, and that the vector arithmetic wraps correctly. For these cases the bench compares every output against a behavioural model on each cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N  = 8,
  parameter int IW = irq_pkg::idx_width(N)
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          hit
);
  logic [N:0]   taken;
  logic [N-1:0] win;

  assign taken[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_chain
    assign win[g]     = req[g] & ~taken[g];
    assign taken[g+1] = taken[g] | req[g];
  end

  always_comb begin
    idx = '0;
    for (int k = 0; k < N; k++)
      if (win[k]) idx = idx | IW'(k);
  end

  assign hit = taken[N];
endmodule

// File: rtl/grant_hold.sv
module grant_hold #(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_grant,
  input  logic [IW-1:0] pick_idx,
  input  logic          pick_hit,
  output logic [IW-1:0] sel_idx,
  output logic          sel_hit
);
  logic          gnt_q;
  logic [IW-1:0] idx_q;
  logic          hit_q;
  logic          first;

  assign first = cpu_grant & ~gnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q <= 1'b0;
      idx_q <= '0;
      hit_q <= 1'b0;
    end else begin
      gnt_q <= cpu_grant;
      if (first) begin
        idx_q <= pick_idx;
        hit_q <= pick_hit;
      end
    end
  end

  assign sel_idx = first ? pick_idx : idx_q;
  assign sel_hit = first ? pick_hit : hit_q;

  // R4: choice frozen across a continuing grant
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_grant && gnt_q) |-> ($stable(sel_idx) && $stable(sel_hit)));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int N_SRC = 8,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_in,
  input  logic [N_SRC-1:0] irq_in,
  input  logic [N_SRC-1:0] mask_in,
  input  logic [VEC_W-1:0] vec_base,
  input  logic             cpu_grant,
  output logic             cpu_irq,
  output logic [N_SRC-1:0] dev_ack,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_data,
  output logic [N_SRC-1:0] pend_stat
);
  localparam int IW = irq_pkg::idx_width(N_SRC);

  logic [N_SRC-1:0] elig;
  logic [IW-1:0]    pick_idx, sel_idx;
  logic             pick_hit, sel_hit, live;

  assign elig      = irq_in & ~mask_in & {N_SRC{en_in}};
  assign pend_stat = irq_in;

  prio_pick #(.N(N_SRC), .IW(IW)) u_pick (
    .req(elig), .idx(pick_idx), .hit(pick_hit)
  );

  grant_hold #(.IW(IW)) u_hold (
    .clk(clk), .rst_n(rst_n), .cpu_grant(cpu_grant),
    .pick_idx(pick_idx), .pick_hit(pick_hit),
    .sel_idx(sel_idx), .sel_hit(sel_hit)
  );

  assign cpu_irq   = pick_hit;
  assign live      = cpu_grant & sel_hit;
  assign vec_valid = live;
  assign vec_data  = live ? vec_base + VEC_W'(sel_idx) : '0;

  always_comb begin
    dev_ack = '0;
    if (live) dev_ack[sel_idx] = 1'b1;
  end

  // R1: combined request only with global enable
  a_r1_enable: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (en_in && (pend_stat != '0)));
  // R3: one device granted at most
  a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_ack));
  // R5: grant lines and vector strobe travel together, only under grant
  a_r5_ack_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack != '0) == vec_valid);
  a_r5_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> cpu_grant);
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> (vec_data == '0));
  // R6: first granted device was requesting and unmasked
  a_r6_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> ((dev_ack & (mask_in | ~irq_in)) == '0));
endmodule

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
  localparam int N = 8;
  logic clk = 0, rst_n = 0, en_in = 0, cpu_grant = 0;
  logic [N-1:0] irq_in = '0, mask_in = '0;
  logic [7:0] vec_base = 8'h40;
  logic cpu_irq, vec_valid;
  logic [N-1:0] dev_ack, pend_stat;
  logic [7:0] vec_data;
  int checks = 0, fails = 0;
  bit done = 0;

  vec_irq_ctrl i_vec_irq_ctrl (.*);

  always #2 clk = ~clk;

  // behavioural reference state
  bit m_gq = 0, m_hit = 0;
  int m_sel = 0;

  function automatic int lowest(input logic [N-1:0] v);
    for (int k = 0; k < N; k++) if (v[k]) return k;
    return -1;
  endfunction

  function automatic logic [N-1:0] eligible();
    return en_in ? (irq_in & ~mask_in) : '0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_gq = 0; m_hit = 0; m_sel = 0; end
    else begin
      if (cpu_grant && !m_gq) begin
        m_hit = (eligible() != 0);
        m_sel = m_hit ? lowest(eligible()) : 0;
      end
      m_gq = cpu_grant;
    end
  end

  task automatic chk(input string r, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", r, what, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    #1;
    if (!done) begin
      bit ch; int cs; logic [N-1:0] ea; logic [7:0] ed;
      if (cpu_grant && !m_gq) begin ch = (eligible() != 0); cs = ch ? lowest(eligible()) : 0; end
      else begin ch = m_hit; cs = m_sel; end
      ea = (cpu_grant && ch) ? (N'(1) << cs) : '0;
      ed = (cpu_grant && ch) ? vec_base + 8'(cs) : 8'h0;
      chk("R1/R6", "cpu_irq", int'(cpu_irq), int'(eligible() != 0));
      chk("R2", "pend_stat", int'(pend_stat), int'(irq_in));
      chk("R3/R4/R7/R8", "dev_ack", int'(dev_ack), int'(ea));
      chk("R5", "vec_valid", int'(vec_valid), int'(cpu_grant && ch));
      chk("R5", "vec_data", int'(vec_data), int'(ed));
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R9: reset state, then grant already high at release
    wait_cyc(3);
    irq_in = 8'h04; en_in = 1; cpu_grant = 1;
    wait_cyc(1);
    rst_n = 1;
    wait_cyc(2);
    cpu_grant = 0; irq_in = 0; wait_cyc(2);
    // R1 R3 R5: single request from device 5
    irq_in = 8'h20; wait_cyc(2);
    cpu_grant = 1; wait_cyc(1);
    irq_in = 0; wait_cyc(2);               // R4: device drops, vector held
    cpu_grant = 0; wait_cyc(2);
    // R3 R8: simultaneous 3 and 6 -> 3 wins, 6 stays pending
    irq_in = 8'h48; cpu_grant = 1; wait_cyc(2);
    irq_in = 8'h40; wait_cyc(1);
    irq_in = 8'h41; wait_cyc(1);           // R4: higher arrives mid-grant, no change
    cpu_grant = 0; irq_in = 8'h40; wait_cyc(1);
    cpu_grant = 1; wait_cyc(2);            // R8: device 6 now served
    cpu_grant = 0; irq_in = 0; wait_cyc(1);
    // R6: mask hides device 1, device 4 wins
    irq_in = 8'h12; mask_in = 8'h02; wait_cyc(1);
    cpu_grant = 1; wait_cyc(2);
    mask_in = 8'h10; wait_cyc(1);          // R4: mask change mid-grant ignored
    cpu_grant = 0; mask_in = 8'hFF; wait_cyc(2);
    // R6: global enable low blocks all
    mask_in = 0; en_in = 0; cpu_grant = 1; wait_cyc(2);
    cpu_grant = 0; wait_cyc(1);
    // R7: empty grant stays empty even if request arrives
    en_in = 1; irq_in = 0; cpu_grant = 1; wait_cyc(1);
    irq_in = 8'h01; wait_cyc(2);
    cpu_grant = 0; wait_cyc(1);
    // R5: highest index and vector wrap
    vec_base = 8'hFC; irq_in = 8'h80; cpu_grant = 1; wait_cyc(2);
    vec_base = 8'h10; wait_cyc(1);          // live base change
    cpu_grant = 0; irq_in = 0; wait_cyc(1);
    // R3: all requesting -> device 0
    irq_in = 8'hFF; cpu_grant = 1; wait_cyc(2);
    cpu_grant = 0; irq_in = 0; wait_cyc(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule